// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the chain of extended capability headers that sits in the upper part of a 4 KB configuration space. Each header is one 32-bit word that carries a capability ID, a version and the byte offset of the next header. Given a requested ID, the engine reads headers one at a time through a single-port memory interface with one cycle of read latency. It stops at the first header whose ID matches, or at the header whose next offset is zero. It reports the offset of the match, or zero on a miss, together with the offset of the header visited just before that result.

The same engine also adds a capability to the chain. For an add at any offset other than the chain root, it first walks to the tail using a search value that no 16-bit ID can equal. It then rewrites only the tail's next field, writes the new header with a next field of zero, and clears the write-mask and write-one-to-clear-mask words that cover the new region, which makes the region read-only. Pointers that are misaligned or outside the legal window stop the walk with an error. A hop limit stops a walk around a corrupted, circular chain.

Top module: `capw_walker`

## Requirements
- R1: A header word holds the ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A match compares only bits 15:0 with the request.
- R2: Every walk begins with a read of byte offset 0x100. If that word is all zeros, a lookup returns offset 0 and predecessor 0 after exactly one read.
- R3: On a hit the result is the byte offset of the matching header. The predecessor is the offset of the header read just before it, or 0 when the match is the root.
- R4: When a header with a next field of zero is reached without a match, the result is 0 and the predecessor is the offset of that last header.
- R5: A request with bit 16 of `cmd_id` set never matches, so a lookup with it reports the chain tail as predecessor. An add always searches with such a value.
- R6: An add at an offset other than 0x100 rewrites bits 31:20 of the tail header to the new offset and leaves bits 19:0 of the tail unchanged. It then writes the new header as {12'h000, version, ID}, returns the new offset as result and the tail as predecessor.
- R7: An add at offset 0x100 performs no reads, writes the new header at 0x100 and returns predecessor 0.
- R8: A non-zero next pointer, or an add offset, that is not a multiple of 4 or lies outside 0x100..0xFF8 ends the command with `err_ptr` high in the `done` cycle and result 0. An add at a non-root offset onto an empty chain also raises `err_ptr` and writes nothing.
- R9: An add clears, through `mask_we`, exactly the words from the new offset through offset + size - 1. It clears no word outside that range.
- R10: A walk that reads MAX_HOPS headers and still finds a non-zero next pointer ends with `err_loop` high in the `done` cycle and result 0.
- R11: `done` is a one-cycle pulse. `busy` is high from the cycle after a command is accepted until the `done` cycle. Read data is taken one cycle after `mem_re`, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command (sampled while idle) |
| cmd_append | input | 1 | 1 = add capability, 0 = lookup |
| cmd_id | input | 17 | Requested ID; bit 16 set means "match nothing" |
| cmd_ver | input | 4 | Version for an added header |
| cmd_offset | input | 12 | Byte offset of the added header |
| cmd_size | input | 12 | Byte size of the added region (multiple of 4) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_offset | output | 12 | Match or new header offset, 0 otherwise |
| res_prev | output | 12 | Offset of the preceding header |
| err_ptr | output | 1 | Illegal pointer or offset, valid with done |
| err_loop | output | 1 | Hop limit reached, valid with done |
| mem_re | output | 1 | Configuration memory read strobe |
| mem_we | output | 1 | Configuration memory write strobe |
| mem_addr | output | 10 | Word address for read or write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| mask_we | output | 1 | Clear both mask words at mask_addr |
| mask_addr | output | 10 | Word address of the mask words to clear |

## Verification
The bench builds the block with its defaults: root at 0x100, top of the window at 0xFF8, and a hop limit of 64. These values put the upper pointer limit, a header at the very top of the window, and a three-entry circular chain within reach. The circular chain reaches the limit after exactly 64 reads, which the bench counts. With a hop limit of 64 the loop case runs in well under a thousand cycles, so the bench can observe the full error path directly instead of only its start.

// File: rtl/capw_pkg.sv
// Shared definitions for the capability chain walker.
// Assumes the fixed 32-bit header layout of the extended capability chain.
package capw_pkg;
    localparam int unsigned CAP_PTR_W = 12;   // byte offset width within 4 KB space
    localparam int unsigned CAP_ID_W  = 16;

    typedef struct packed {
        logic [CAP_PTR_W-1:0] nxt;
        logic [3:0]           ver;
        logic [CAP_ID_W-1:0]  id;
    } capw_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_EV,
        ST_WTAIL,
        ST_WNEW,
        ST_CLR
    } capw_state_e;
endpackage

// File: rtl/capw_ptr_check.sv
// Legality check for a chain pointer: word aligned and inside [LO, HI].
// Assumes LO and HI are themselves word aligned.
module capw_ptr_check
    import capw_pkg::*;
#(
    parameter int unsigned LO = 'h100,
    parameter int unsigned HI = 'hFF8
) (
    input  logic [CAP_PTR_W-1:0] ptr,
    output logic                 ok
);
    localparam logic [CAP_PTR_W-1:0] LO_P = CAP_PTR_W'(LO);
    localparam logic [CAP_PTR_W-1:0] HI_P = CAP_PTR_W'(HI);

    // Combine alignment and window tests
    always_comb begin
        ok = (ptr[1:0] == 2'b00) && (ptr >= LO_P) && (ptr <= HI_P);
    end
endmodule

// File: rtl/capw_mask_clear.sv
// Issues one mask-clear strobe per word for COUNT consecutive words from BASE.
// Assumes start is a single-cycle pulse and is not raised while active.
module capw_mask_clear #(
    parameter int unsigned WA = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [WA-1:0] base,
    input  logic [WA:0]   count,
    output logic          we,
    output logic [WA-1:0] addr,
    output logic          active
);
    logic [WA-1:0] idx;
    logic [WA:0]   rem;

    // Step through the region one word per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            rem    <= '0;
        end else if (start) begin
            active <= (count != '0);
            idx    <= base;
            rem    <= count;
        end else if (active) begin
            idx <= idx + 1'b1;
            rem <= rem - 1'b1;
            if (rem == {{WA{1'b0}}, 1'b1}) begin
                active <= 1'b0;
            end
        end
    end

    // Drive the strobe straight from the running state
    always_comb begin
        we   = active;
        addr = idx;
    end
endmodule

// File: rtl/capw_walker.sv
// Capability chain walker: looks up an ID in the header chain and appends
// new headers at the tail. Assumes a memory with one cycle of read latency
// and that the caller's new regions do not overlap existing ones.
module capw_walker
    import capw_pkg::*;
#(
    parameter int unsigned BASE     = 'h100,
    parameter int unsigned LIMIT    = 'hFF8,
    parameter int unsigned MAX_HOPS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic                  cmd_append,
    input  logic [CAP_ID_W:0]     cmd_id,
    input  logic [3:0]            cmd_ver,
    input  logic [CAP_PTR_W-1:0]  cmd_offset,
    input  logic [CAP_PTR_W-1:0]  cmd_size,
    output logic                  busy,
    output logic                  done,
    output logic [CAP_PTR_W-1:0]  res_offset,
    output logic [CAP_PTR_W-1:0]  res_prev,
    output logic                  err_ptr,
    output logic                  err_loop,
    output logic                  mem_re,
    output logic                  mem_we,
    output logic [CAP_PTR_W-3:0]  mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    output logic                  mask_we,
    output logic [CAP_PTR_W-3:0]  mask_addr
);
    localparam int unsigned WA    = CAP_PTR_W - 2;
    localparam int unsigned HOP_W = (MAX_HOPS > 1) ? $clog2(MAX_HOPS) : 1;
    localparam logic [HOP_W-1:0]     HOP_LAST = HOP_W'(MAX_HOPS - 1);
    localparam logic [CAP_PTR_W-1:0] BASE_P   = CAP_PTR_W'(BASE);
    localparam logic [CAP_ID_W:0]    SENTINEL = {1'b1, {CAP_ID_W{1'b0}}};

    capw_state_e          state;
    logic [CAP_PTR_W-1:0] cur, prev, off;
    logic [CAP_ID_W:0]    sid;
    logic [CAP_ID_W-1:0]  nid;
    logic [3:0]           nver;
    logic                 is_app;
    logic [WA-1:0]        size_w;
    capw_hdr_t            tail_q;
    logic [HOP_W-1:0]     hops;
    capw_hdr_t            hdr;
    logic [1:0][CAP_PTR_W-1:0] chk_ptr;
    logic [1:0]           chk_ok;
    logic                 clr_start, clr_active;

    assign hdr        = capw_hdr_t'(mem_rdata);
    assign chk_ptr[0] = hdr.nxt;
    assign chk_ptr[1] = cmd_offset;

    // One pointer checker for the header chain, one for the add offset
    for (genvar g = 0; g < 2; g++) begin : g_chk
        capw_ptr_check #(.LO(BASE), .HI(LIMIT)) u_chk (
            .ptr (chk_ptr[g]),
            .ok  (chk_ok[g])
        );
    end

    capw_mask_clear #(.WA(WA)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (clr_start),
        .base   (off[CAP_PTR_W-1:2]),
        .count  ({1'b0, size_w}),
        .we     (mask_we),
        .addr   (mask_addr),
        .active (clr_active)
    );

    // Memory strobes, address and write data for the current state
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        clr_start = 1'b0;
        case (state)
            ST_RD: begin
                mem_re   = 1'b1;
                mem_addr = cur[CAP_PTR_W-1:2];
            end
            ST_WTAIL: begin
                mem_we    = 1'b1;
                mem_addr  = prev[CAP_PTR_W-1:2];
                mem_wdata = {off, tail_q.ver, tail_q.id};
            end
            ST_WNEW: begin
                mem_we    = 1'b1;
                mem_addr  = off[CAP_PTR_W-1:2];
                mem_wdata = {{CAP_PTR_W{1'b0}}, nver, nid};
                clr_start = 1'b1;
            end
            default: ;
        endcase
        busy = (state != ST_IDLE);
    end

    // Command sequencer: accept, walk, patch, write, clear, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur        <= '0;
            prev       <= '0;
            off        <= '0;
            sid        <= '0;
            nid        <= '0;
            nver       <= '0;
            is_app     <= 1'b0;
            size_w     <= '0;
            tail_q     <= '0;
            hops       <= '0;
            done       <= 1'b0;
            err_ptr    <= 1'b0;
            err_loop   <= 1'b0;
            res_offset <= '0;
            res_prev   <= '0;
        end else begin
            done     <= 1'b0;
            err_ptr  <= 1'b0;
            err_loop <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        is_app <= cmd_append;
                        sid    <= cmd_append ? SENTINEL : cmd_id;
                        nid    <= cmd_id[CAP_ID_W-1:0];
                        nver   <= cmd_ver;
                        off    <= cmd_offset;
                        size_w <= cmd_size[CAP_PTR_W-1:2];
                        cur    <= BASE_P;
                        prev   <= '0;
                        hops   <= '0;
                        if (cmd_append && !chk_ok[1]) begin
                            done       <= 1'b1;
                            err_ptr    <= 1'b1;
                            res_offset <= '0;
                            res_prev   <= '0;
                        end else if (cmd_append && cmd_offset == BASE_P) begin
                            state <= ST_WNEW;
                        end else begin
                            state <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    state <= ST_EV;
                end
                ST_EV: begin
                    if (hops == '0 && mem_rdata == 32'h0) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        err_ptr    <= is_app;
                        res_offset <= '0;
                        res_prev   <= '0;
                    end else if ({1'b0, hdr.id} == sid) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        res_offset <= cur;
                        res_prev   <= prev;
                    end else if (hdr.nxt == '0) begin
                        prev   <= cur;
                        tail_q <= hdr;
                        if (is_app) begin
                            state <= ST_WTAIL;
                        end else begin
                            state      <= ST_IDLE;
                            done       <= 1'b1;
                            res_offset <= '0;
                            res_prev   <= cur;
                        end
                    end else if (!chk_ok[0] || hops == HOP_LAST) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        err_ptr    <= !chk_ok[0];
                        err_loop   <= chk_ok[0];
                        res_offset <= '0;
                        res_prev   <= cur;
                    end else begin
                        prev  <= cur;
                        cur   <= hdr.nxt;
                        hops  <= hops + 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_WTAIL: begin
                    state <= ST_WNEW;
                end
                ST_WNEW: begin
                    state <= ST_CLR;
                end
                ST_CLR: begin
                    if (!clr_active) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        res_offset <= off;
                        res_prev   <= prev;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/capw_walker_chk.sv
// Protocol and result checks for capw_walker, attached by bind.
// Assumes the same BASE and LIMIT as the bound instance.
module capw_walker_chk
    import capw_pkg::*;
#(
    parameter int unsigned BASE  = 'h100,
    parameter int unsigned LIMIT = 'hFF8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic [CAP_PTR_W-1:0] res_offset,
    input logic [CAP_PTR_W-1:0] res_prev,
    input logic                 err_ptr,
    input logic                 err_loop,
    input logic                 mem_re,
    input logic                 mem_we,
    input logic [CAP_PTR_W-3:0] mem_addr,
    input logic                 mask_we
);
    localparam logic [CAP_PTR_W-3:0] BASE_W  = (CAP_PTR_W-2)'(BASE >> 2);
    localparam logic [CAP_PTR_W-3:0] LIMIT_W = (CAP_PTR_W-2)'(LIMIT >> 2);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
    AST_NO_RD_WR: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R11
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) (err_ptr || err_loop) |-> done); // R8
    AST_PTR_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) err_ptr |-> res_offset == '0); // R8
    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) mem_re |-> (mem_addr >= BASE_W && mem_addr <= LIMIT_W)); // R8
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({err_ptr, err_loop})); // R10
    AST_LOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) err_loop |-> res_offset == '0); // R10
    AST_MASK_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mask_we |-> busy); // R9
    AST_FIRST_RD_ROOT: assert property (@(posedge clk) disable iff (!rst_n) ($rose(busy) && mem_re) |-> mem_addr == BASE_W); // R2
    AST_HIT_PREV_DIFF: assert property (@(posedge clk) disable iff (!rst_n) (done && res_offset != '0) |-> res_prev != res_offset); // R3
endmodule

bind capw_walker capw_walker_chk #(.BASE(BASE), .LIMIT(LIMIT)) u_walker_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .res_offset (res_offset),
    .res_prev   (res_prev),
    .err_ptr    (err_ptr),
    .err_loop   (err_loop),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mask_we    (mask_we)
);

// File: tb/capw_walker_test.sv
`timescale 1ns/1ps
module capw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_append = 1'b0;
    logic [16:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_offset = '0;
    logic [11:0] cmd_size = '0;
    logic        busy, done, err_ptr, err_loop, mem_re, mem_we, mask_we;
    logic [11:0] res_offset, res_prev;
    logic [9:0]  mem_addr, mask_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem   [0:1023];
    logic [31:0] wmask [0:1023];
    int rd_cnt = 0, wr_cnt = 0;
    int n_chk = 0, n_bad = 0;
    logic [11:0] r_off, r_prev;
    logic r_eptr, r_eloop;

    always #2.5 clk = ~clk;

    capw_walker uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
        .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_offset(cmd_offset), .cmd_size(cmd_size),
        .busy(busy), .done(done), .res_offset(res_offset), .res_prev(res_prev),
        .err_ptr(err_ptr), .err_loop(err_loop), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mask_we(mask_we), .mask_addr(mask_addr)
    );

    // Memory model: one cycle read latency, shared mask clear strobe
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mask_we) wmask[mask_addr] <= 32'h0;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 32'h0;
            wmask[i] = 32'hFFFF_FFFF;
        end
    endtask

    task automatic run(input logic app, input logic [16:0] id, input logic [3:0] ver,
                       input logic [11:0] off, input logic [11:0] size);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_append = app; cmd_id = id; cmd_ver = ver;
        cmd_offset = off; cmd_size = size; rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R11", "done seen", {31'h0, done}, 32'h1);
        r_off = res_offset; r_prev = res_prev; r_eptr = err_ptr; r_eloop = err_loop;
        @(negedge clk);
        chk("R11", "done one cycle", {31'h0, done}, 32'h0);
        chk("R11", "idle after done", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R11", "reset busy", {31'h0, busy}, 32'h0);
        chk("R11", "reset done", {31'h0, done}, 32'h0);
        chk("R11", "reset strobes", {29'h0, mem_re, mem_we, mask_we}, 32'h0);
    endtask

    task automatic t_empty();
        wipe();
        run(1'b0, 17'h00001, 4'h0, 12'h0, 12'h0);
        chk("R2", "empty result", r_off, 32'h0);
        chk("R2", "empty prev", r_prev, 32'h0);
        chk("R2", "empty reads", rd_cnt, 32'd1);
        chk("R2", "empty no err", {r_eptr, r_eloop}, 32'h0);
    endtask

    task automatic t_build();
        run(1'b1, 17'h00001, 4'h1, 12'h100, 12'd16);
        chk("R7", "root add reads", rd_cnt, 32'd0);
        chk("R7", "root add prev", r_prev, 32'h0);
        chk("R7", "root add result", r_off, 32'h100);
        chk("R6", "root header", mem['h40], 32'h0001_0001);
        chk("R9", "mask first", wmask['h40], 32'h0);
        chk("R9", "mask last", wmask['h43], 32'h0);
        chk("R9", "mask after", wmask['h44], 32'hFFFF_FFFF);
        chk("R9", "mask before", wmask['h3F], 32'hFFFF_FFFF);
        run(1'b1, 17'h0000B, 4'h2, 12'h150, 12'd8);
        chk("R5", "tail walk reads", rd_cnt, 32'd1);
        chk("R6", "tail patched", mem['h40], 32'h1501_0001);
        chk("R6", "new header", mem['h54], 32'h0002_000B);
        chk("R6", "add result", r_off, 32'h150);
        chk("R6", "add prev", r_prev, 32'h100);
        chk("R6", "add writes", wr_cnt, 32'd2);
        chk("R9", "mask 2nd region", wmask['h55], 32'h0);
        chk("R9", "mask past 2nd", wmask['h56], 32'hFFFF_FFFF);
        run(1'b1, 17'h00010, 4'h3, 12'h200, 12'd8);
        chk("R6", "second tail patched", mem['h54], 32'h2002_000B);
        chk("R6", "third header", mem['h80], 32'h0003_0010);
        chk("R6", "third prev", r_prev, 32'h150);
        chk("R5", "third walk reads", rd_cnt, 32'd2);
    endtask

    task automatic t_find();
        run(1'b0, 17'h0000B, 4'h0, 12'h0, 12'h0);
        chk("R3", "mid hit", r_off, 32'h150);
        chk("R3", "mid prev", r_prev, 32'h100);
        chk("R3", "mid reads", rd_cnt, 32'd2);
        run(1'b0, 17'h00001, 4'h0, 12'h0, 12'h0);
        chk("R3", "root hit", r_off, 32'h100);
        chk("R3", "root prev", r_prev, 32'h0);
        run(1'b0, 17'h00010, 4'h0, 12'h0, 12'h0);
        chk("R3", "tail hit", r_off, 32'h200);
        chk("R3", "tail hit prev", r_prev, 32'h150);
        run(1'b0, 17'h00002, 4'h0, 12'h0, 12'h0);
        chk("R1", "version not matched", r_off, 32'h0);
        chk("R4", "miss prev", r_prev, 32'h200);
        chk("R4", "miss reads", rd_cnt, 32'd3);
        run(1'b0, 17'h02002, 4'h0, 12'h0, 12'h0);
        chk("R1", "upper half not matched", r_off, 32'h0);
        run(1'b0, 17'h10010, 4'h0, 12'h0, 12'h0);
        chk("R5", "sentinel no match", r_off, 32'h0);
        chk("R5", "sentinel tail", r_prev, 32'h200);
    endtask

    task automatic t_bad_ptr();
        mem['h80] = 32'h0F00_0010;
        run(1'b0, 17'h07777, 4'h0, 12'h0, 12'h0);
        chk("R8", "below window err", {31'h0, r_eptr}, 32'h1);
        chk("R8", "below window result", r_off, 32'h0);
        mem['h80] = 32'hFFC0_0010;
        run(1'b0, 17'h07777, 4'h0, 12'h0, 12'h0);
        chk("R8", "above window err", {31'h0, r_eptr}, 32'h1);
        mem['h80] = 32'h2020_0010;
        run(1'b0, 17'h07777, 4'h0, 12'h0, 12'h0);
        chk("R8", "unaligned err", {31'h0, r_eptr}, 32'h1);
        mem['h80] = 32'hFF80_0010;
        mem['h3FE] = 32'h0000_0099;
        run(1'b0, 17'h00099, 4'h0, 12'h0, 12'h0);
        chk("R8", "top of window ok", {31'h0, r_eptr}, 32'h0);
        chk("R3", "top of window hit", r_off, 32'hFF8);
        chk("R3", "top of window prev", r_prev, 32'h200);
    endtask

    task automatic t_loop();
        mem['h80] = 32'h1000_0010;
        run(1'b0, 17'h07777, 4'h0, 12'h0, 12'h0);
        chk("R10", "loop flag", {31'h0, r_eloop}, 32'h1);
        chk("R10", "loop result", r_off, 32'h0);
        chk("R10", "loop reads", rd_cnt, 32'd64);
        chk("R10", "loop no ptr err", {31'h0, r_eptr}, 32'h0);
    endtask

    task automatic t_bad_add();
        wipe();
        run(1'b1, 17'h00005, 4'h1, 12'h180, 12'd8);
        chk("R8", "empty add err", {31'h0, r_eptr}, 32'h1);
        chk("R8", "empty add no write", wr_cnt, 32'd0);
        chk("R8", "empty add untouched", mem['h60], 32'h0);
        chk("R9", "empty add masks kept", wmask['h60], 32'hFFFF_FFFF);
        run(1'b1, 17'h00005, 4'h1, 12'h182, 12'd8);
        chk("R8", "misaligned add err", {31'h0, r_eptr}, 32'h1);
        chk("R8", "misaligned add reads", rd_cnt, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_build();
        t_find();
        t_bad_ptr();
        t_loop();
        t_bad_add();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule